// File: doc/BRIEF.md
# GPIO Edge and Level Interrupt Aggregator

This block turns a vector of 32 general-purpose input bits, already synchronized and already corrected for polarity, into four interrupt lines for an upstream interrupt controller. Each pin can raise a request in two ways. A level request follows the live input bit. An edge request comes from a sticky cause bit that records a low-to-high change of the input. Separate per-pin enable registers gate the level and the edge requests.

The two gated requests are combined for each pin. The pin requests are then reduced in fixed groups of eight, and each group drives one registered interrupt output. Software uses a small write/read register port to program the two enable registers and to acknowledge pending edges. An edge is acknowledged by writing a zero to its cause bit. Software can emulate both-edge detection by flipping the polarity outside this block. The block itself sees only the corrected input.

The offset between the cause register and the two enable registers is a parameter. This lets the block drop into different register layouts.

Top module: `gpio_irq_agg`

## Requirements
- R1: While reset is asserted and right after it, the cause, edge-enable and level-enable registers are all zero and every bit of irqOut is 0.
- R2: The level request of pin i is pinLevel[i] AND levelEnable[i]. It is not stored, so it drops once the input drops.
- R3: Cause bit i is set by a 0-to-1 change of pinLevel[i] between two consecutive clock edges. A 1-to-0 change sets nothing. No change is seen in the first cycle after reset, even when inputs are already high.
- R4: The edge request of pin i is cause[i] AND edgeEnable[i]. A pending cause whose enable is 0 raises no interrupt.
- R5: irqOut[g] is the OR of the requests of pins 8g to 8g+7, where the request of a pin is its level request OR its edge request.
- R6: A write to the cause register clears every bit written as 0 and leaves every bit written as 1 unchanged. Writing all zeros clears every pending edge.
- R7: When a write clears a cause bit in the same cycle that a new rising edge arrives on that pin, the bit stays set.
- R8: The cause register sits at byte address 0x14, the edge-enable register at 0x18+MASK_OFS and the level-enable register at 0x1C+MASK_OFS. The default MASK_OFS is 0x20. Each register reads back what it holds. Any other address reads 0, and writes to other addresses change nothing.
- R9: irqOut is registered. It rises on the clock edge after a request appears and falls on the clock edge after the cause or enable bit that produced it is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinLevel | input | 32 | Synchronized, polarity-corrected input bits |
| busWrEn | input | 1 | Register write strobe, one cycle per write |
| busAddr | input | 8 | Register byte address for write and read |
| busWrData | input | 32 | Register write data |
| busRdData | output | 32 | Register read data, combinational from busAddr |
| irqOut | output | 4 | Grouped interrupt lines, one per eight pins |

## Verification
The hardest case to reach is a software clear and a fresh rising edge landing on the same cause bit in the same clock cycle. Only in that cycle does the priority between acknowledge and capture decide the result. The stimulus reaches it by holding the pin low until things settle, then raising the pin and driving the clearing write at the same falling edge, so that one rising edge samples both. A second hard case is the one-cycle lag of the registered outputs after an acknowledge. It is reached by checking irqOut one cycle and two cycles after the clearing write. The no-false-edge rule after reset is reached by holding every input high throughout reset.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  typedef enum logic [1:0] {
    RD_NONE  = 2'd0,
    RD_CAUSE = 2'd1,
    RD_EMASK = 2'd2,
    RD_LMASK = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic   wrCause;
    logic   wrEdgeMask;
    logic   wrLevelMask;
    rdSel_e rdSel;
  } ctlStrobes_t;

endpackage

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int MASK_OFS = 32
) (
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  output ctlStrobes_t       strobes
);

  localparam int CAUSE_ADDR = 'h14;
  localparam int EMASK_ADDR = 'h18 + MASK_OFS;
  localparam int LMASK_ADDR = 'h1C + MASK_OFS;

  logic hitCause, hitEdgeMask, hitLevelMask;

  assign hitCause     = (busAddr == ADDR_W'(CAUSE_ADDR));
  assign hitEdgeMask  = (busAddr == ADDR_W'(EMASK_ADDR));
  assign hitLevelMask = (busAddr == ADDR_W'(LMASK_ADDR));

  always_comb begin
    strobes.wrCause     = busWrEn && hitCause;
    strobes.wrEdgeMask  = busWrEn && hitEdgeMask;
    strobes.wrLevelMask = busWrEn && hitLevelMask;
    if (hitCause)
      strobes.rdSel = RD_CAUSE;
    else if (hitEdgeMask)
      strobes.rdSel = RD_EMASK;
    else if (hitLevelMask)
      strobes.rdSel = RD_LMASK;
    else
      strobes.rdSel = RD_NONE;
  end

endmodule

// File: rtl/gpio_irq_datapath.sv
module gpio_irq_datapath
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS   = 32,
  parameter int GROUP_SIZE = 8
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [NUM_PINS-1:0]            pinLevel,
  input  ctlStrobes_t                    strobes,
  input  logic [NUM_PINS-1:0]            busWrData,
  output logic [NUM_PINS-1:0]            busRdData,
  output logic [NUM_PINS/GROUP_SIZE-1:0] irqOut
);

  localparam int NUM_GROUPS = NUM_PINS / GROUP_SIZE;

  logic [NUM_PINS-1:0]   prevLevel, causeQ, edgeMaskQ, levelMaskQ;
  logic [NUM_PINS-1:0]   riseVec, keepVec, pinReq;
  logic                  seeded;
  logic [NUM_GROUPS-1:0] grpReq, irqQ;

  // rising edge only once the history register holds a real sample
  assign riseVec = pinLevel & ~prevLevel & {NUM_PINS{seeded}};
  // write-zero-to-clear: a written 1 keeps the bit
  assign keepVec = strobes.wrCause ? busWrData : {NUM_PINS{1'b1}};
  assign pinReq  = (pinLevel & levelMaskQ) | (causeQ & edgeMaskQ);

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_group
    assign grpReq[g] = |pinReq[g*GROUP_SIZE +: GROUP_SIZE];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevLevel  <= '0;
      seeded     <= 1'b0;
      causeQ     <= '0;
      edgeMaskQ  <= '0;
      levelMaskQ <= '0;
      irqQ       <= '0;
    end else begin
      prevLevel <= pinLevel;
      seeded    <= 1'b1;
      // new edge has priority over a clear in the same cycle
      causeQ    <= (causeQ & keepVec) | riseVec;
      if (strobes.wrEdgeMask)
        edgeMaskQ <= busWrData;
      if (strobes.wrLevelMask)
        levelMaskQ <= busWrData;
      irqQ <= grpReq;
    end
  end

  always_comb begin
    case (strobes.rdSel)
      RD_CAUSE: busRdData = causeQ;
      RD_EMASK: busRdData = edgeMaskQ;
      RD_LMASK: busRdData = levelMaskQ;
      default:  busRdData = '0;
    endcase
  end

  assign irqOut = irqQ;

  // R3 R7
  edge_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|riseVec) |=> ((causeQ & $past(riseVec)) == $past(riseVec)));

  // R3
  cause_origin_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((causeQ & ~$past(causeQ) & ~$past(riseVec)) == '0));

  // R6
  cause_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.wrCause |=> ((causeQ & $past(causeQ)) == $past(causeQ)));

  // R9
  irq_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pinReq == '0) |=> (irqQ == '0));

  // R9
  irq_raise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|pinReq) |=> (|irqQ));

  // R8
  one_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.wrCause, strobes.wrEdgeMask, strobes.wrLevelMask}));

endmodule

// File: rtl/gpio_irq_agg.sv
module gpio_irq_agg
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS   = 32,
  parameter int GROUP_SIZE = 8,
  parameter int ADDR_W     = 8,
  parameter int MASK_OFS   = 32
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [NUM_PINS-1:0]            pinLevel,
  input  logic                           busWrEn,
  input  logic [ADDR_W-1:0]              busAddr,
  input  logic [NUM_PINS-1:0]            busWrData,
  output logic [NUM_PINS-1:0]            busRdData,
  output logic [NUM_PINS/GROUP_SIZE-1:0] irqOut
);

  ctlStrobes_t strobes;

  gpio_irq_ctrl #(
    .ADDR_W  (ADDR_W),
    .MASK_OFS(MASK_OFS)
  ) u_ctrl (
    .busWrEn(busWrEn),
    .busAddr(busAddr),
    .strobes(strobes)
  );

  gpio_irq_datapath #(
    .NUM_PINS  (NUM_PINS),
    .GROUP_SIZE(GROUP_SIZE)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .pinLevel (pinLevel),
    .strobes  (strobes),
    .busWrData(busWrData),
    .busRdData(busRdData),
    .irqOut   (irqOut)
  );

endmodule

// File: tb/gpio_irq_agg_bench.sv
module gpio_irq_agg_bench;

  localparam int         OFS      = 32;
  localparam logic [7:0] A_CAUSE  = 8'h14;
  localparam logic [7:0] A_EMASK  = 8'h18 + 8'(OFS);
  localparam logic [7:0] A_LMASK  = 8'h1C + 8'(OFS);
  localparam int         NROWS    = 6;

  // pre, post, levelEn, edgeEn, expected irq nibble
  typedef struct packed {
    logic [31:0] pre;
    logic [31:0] post;
    logic [31:0] lm;
    logic [31:0] em;
    logic [3:0]  irq;
  } row_t;

  localparam row_t ROWS [NROWS] = '{
    '{32'h0000_0000, 32'h0000_0001, 32'h0000_0000, 32'h0000_0001, 4'b0001},
    '{32'h0000_0000, 32'h0000_0100, 32'h0000_0100, 32'h0000_0000, 4'b0010},
    '{32'h00FF_0000, 32'h0000_0000, 32'h0000_0000, 32'hFFFF_FFFF, 4'b0000},
    '{32'h0000_0000, 32'h8000_0000, 32'h0000_0000, 32'h7FFF_FFFF, 4'b0000},
    '{32'h0000_0000, 32'h0101_0101, 32'h0000_0001, 32'h0100_0000, 4'b1001},
    '{32'h0000_FF00, 32'hFFFF_FFFF, 32'h0000_0000, 32'hFFFF_FFFF, 4'b1101}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] pinLevel = '1;
  logic        busWrEn = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [3:0]  irqOut;
  int          total = 0;
  int          bad = 0;

  always #4 clk = ~clk;

  gpio_irq_agg #(.MASK_OFS(OFS)) u_gpio_irq_agg (
    .clk(clk), .rstN(rstN), .pinLevel(pinLevel), .busWrEn(busWrEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .irqOut(irqOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdData;
  endtask

  task automatic settle2;
    @(posedge clk); @(posedge clk); @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    // R1 R3: all inputs high through reset
    repeat (3) @(negedge clk);
    #1 check("R1 irq in reset", {28'h0, irqOut}, 32'h0);
    @(negedge clk) rstN = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 irq after reset", {28'h0, irqOut}, 32'h0);
    regRead(A_CAUSE, rd); check("R3 no edge after reset", rd, 32'h0);
    regRead(A_EMASK, rd); check("R1 edge enable reset", rd, 32'h0);
    regRead(A_LMASK, rd); check("R1 level enable reset", rd, 32'h0);

    // R8 address map
    regWrite(A_EMASK, 32'hA5A5_5A5A);
    regWrite(A_LMASK, 32'h0F0F_3C3C);
    regWrite(8'h18, 32'hFFFF_FFFF);
    regRead(A_EMASK, rd); check("R8 edge enable readback", rd, 32'hA5A5_5A5A);
    regRead(A_LMASK, rd); check("R8 level enable readback", rd, 32'h0F0F_3C3C);
    regRead(8'h10, rd);   check("R8 unmapped read", rd, 32'h0);
    regWrite(A_EMASK, 32'h0);
    regWrite(A_LMASK, 32'h0);

    // R2 R3 R4 R5 table
    for (int i = 0; i < NROWS; i++) begin
      @(negedge clk) pinLevel = ROWS[i].pre;
      settle2();
      regWrite(A_CAUSE, 32'h0);
      regWrite(A_EMASK, ROWS[i].em);
      regWrite(A_LMASK, ROWS[i].lm);
      pinLevel = ROWS[i].post;
      settle2();
      check("R5 R2 R4 grouped irq", {28'h0, irqOut}, {28'h0, ROWS[i].irq});
      regRead(A_CAUSE, rd);
      check("R3 cause capture", rd, ROWS[i].post & ~ROWS[i].pre);
    end

    // R6 write of ones keeps bits (cause now FFFF00FF)
    regWrite(A_CAUSE, 32'hFFFF_00FE);
    regRead(A_CAUSE, rd); check("R6 write-one keeps", rd, 32'hFFFF_00FE);

    // R7 clear and new edge in same cycle
    @(negedge clk) pinLevel = 32'h0;
    settle2();
    regWrite(A_CAUSE, 32'h0);
    regWrite(A_LMASK, 32'h0);
    regWrite(A_EMASK, 32'h0000_0001);
    @(negedge clk);
    pinLevel = 32'h0000_0001;
    busWrEn = 1'b1; busAddr = A_CAUSE; busWrData = 32'h0;
    @(negedge clk) busWrEn = 1'b0;
    regRead(A_CAUSE, rd); check("R7 edge wins over clear", rd, 32'h1);

    // R9 one-cycle lag on deassert
    @(negedge clk);
    check("R9 irq asserted", {28'h0, irqOut}, 32'h1);
    busWrEn = 1'b1; busAddr = A_CAUSE; busWrData = 32'h0;
    @(negedge clk) busWrEn = 1'b0;
    #1 check("R9 irq held one cycle", {28'h0, irqOut}, 32'h1);
    @(negedge clk);
    check("R9 irq dropped", {28'h0, irqOut}, 32'h0);

    // R2 level not latched
    regWrite(A_EMASK, 32'h0);
    regWrite(A_LMASK, 32'h0000_0100);
    pinLevel = 32'h0000_0100;
    settle2();
    check("R2 level active", {28'h0, irqOut}, 32'h2);
    pinLevel = 32'h0;
    settle2();
    check("R2 level released", {28'h0, irqOut}, 32'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule